// File: doc/BRIEF.md
# Memory Test Error Checker

This block sits on the read-return path of a memory test engine. Each time the engine presents a compare strobe, it checks one chunk of returned read data and its ECC byte against the expected pattern, bit for bit. Lanes can be excluded with masks, and whole comparisons can be skipped by chunk and cacheline enable masks. Mismatches on the remaining lanes build up sticky per-lane and per-byte-group error vectors and a channel error flag.

Two further results come from the same comparisons. A saturating error counter increments according to a selectable counting mode. A stop request tells the test sequencer to halt under one of four stop policies. All status stays set until a clear command. Pattern generation and command sequencing belong to other blocks.

Top module: `memtest_err_chk`

## Requirements
- R1: Lane i (0..63) compares data bit i, and lane 64+j compares ECC bit j. A mismatch on a lane whose data-mask or ECC-mask bit is 0 sets that lane's bit in `lane_err_o` one cycle after the strobe, and the bit stays set. A mask bit of 1 excludes its lane.
- R2: Byte group g covers lanes 8g..8g+7, so group 8 is the ECC byte. A group's bit in `grp_err_o` becomes set and stays set once any of its unmasked lanes mismatches. `chan_err_o` is set once any group has failed.
- R3: A comparison records nothing in three cases: the strobe is low, `chunk_en_i[chunk_idx_i]` is 0, or `cl_en_i[cl_idx_i mod 8]` is 0.
- R4: Stop code 0 never asserts `stop_o`.
- R5: Stop code 1 asserts `stop_o` one cycle after the recorded comparison that brings the number of erroneous comparisons to `nth_i`. An `nth_i` of 0 acts like 1.
- R6: Stop code 2 asserts `stop_o` one cycle after a recorded mismatch that leaves every byte group either failed or fully masked.
- R7: Stop code 3 asserts `stop_o` one cycle after a recorded mismatch that leaves every lane either failed or masked.
- R8: Once asserted, `stop_o` stays high until a clear. It rises only after a comparison strobe.
- R9: The count code selects how `err_cnt_o` advances per erroneous comparison. Code 0 adds 1. Code 1 adds the number of mismatching lanes. Code 2 adds the number of failing byte groups. Code 3 adds 1 only for the first error in a given chunk index.
- R10: `err_cnt_o` saturates at all ones and never wraps.
- R11: A clear (`clr_i` high) zeroes all sticky vectors, the flag, the counter and the stop request one cycle later. If a comparison arrives in the same cycle as the clear, it is discarded.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear all error status |
| cmp_vld_i | input | 1 | Compare strobe |
| act_data_i | input | 64 | Returned read data |
| exp_data_i | input | 64 | Expected data |
| act_ecc_i | input | 8 | Returned ECC bits |
| exp_ecc_i | input | 8 | Expected ECC bits |
| chunk_idx_i | input | 3 | Chunk index of this comparison |
| cl_idx_i | input | 8 | Cacheline index of this comparison |
| stop_mode_i | input | 2 | Stop policy code |
| nth_i | input | 6 | Error number for stop code 1 |
| chunk_en_i | input | 8 | Chunk enable mask |
| cl_en_i | input | 8 | Cacheline enable mask |
| data_mask_i | input | 64 | Data lane exclusion mask |
| ecc_mask_i | input | 8 | ECC lane exclusion mask |
| cnt_mode_i | input | 2 | Counting mode code |
| stop_o | output | 1 | Registered stop request |
| lane_err_o | output | 72 | Sticky per-lane errors |
| grp_err_o | output | 9 | Sticky per-byte-group errors |
| err_cnt_o | output | 16 | Saturating error counter |
| chan_err_o | output | 1 | Channel error flag |

## Verification
The properties assume that configuration inputs (masks, stop and count codes, N) stay constant between clears. Under that assumption, "stop never rises under code 0" and the stop-condition checks can be judged from the current configuration alone. The stimulus therefore changes configuration only just before a clear, and never while a test is accumulating status. The properties also assume `clr_i` is the only way status shrinks. The bench never pulses reset except at the start.

// File: rtl/memtest_err_pkg.sv
package memtest_err_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    STOP_NEVER    = 2'd0,
    STOP_NTH      = 2'd1,
    STOP_ALL_GRP  = 2'd2,
    STOP_ALL_LANE = 2'd3
  } stop_mode_e;

  typedef enum logic [1:0] {
    CNT_CHAN  = 2'd0,
    CNT_LANE  = 2'd1,
    CNT_GRP   = 2'd2,
    CNT_CHUNK = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/memtest_lane_cmp.sv
module memtest_lane_cmp
  import memtest_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ECC_W    = 8,
  parameter int CHUNKS   = 8,
  parameter int CL_EN_W  = 8,
  parameter int CL_IDX_W = 8,
  localparam int LANES   = DATA_W + ECC_W,
  localparam int GROUPS  = LANES / BYTE_W,
  localparam int CHK_W   = $clog2(CHUNKS)
) (
  input  logic                vld,
  input  logic [DATA_W-1:0]   act_data,
  input  logic [DATA_W-1:0]   exp_data,
  input  logic [ECC_W-1:0]    act_ecc,
  input  logic [ECC_W-1:0]    exp_ecc,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [CHUNKS-1:0]   chunk_en,
  input  logic [CL_EN_W-1:0]  cl_en,
  input  logic [CHK_W-1:0]    chunk_idx,
  input  logic [CL_IDX_W-1:0] cl_idx,
  output logic [LANES-1:0]    lane_mis,
  output logic [GROUPS-1:0]   grp_mis,
  output logic [GROUPS-1:0]   grp_masked,
  output logic                hit
);
  logic cl_ok;
  logic qual;

  always_comb begin
    cl_ok = 1'b0;
    for (int i = 0; i < CL_EN_W; i++)
      if (cl_idx % CL_IDX_W'(CL_EN_W) == CL_IDX_W'(i)) cl_ok = cl_en[i];
  end

  assign qual     = vld & chunk_en[chunk_idx] & cl_ok;
  assign lane_mis = qual ? (({act_ecc, act_data} ^ {exp_ecc, exp_data}) & ~lane_mask)
                         : '0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_mis[g]    = |lane_mis[g*BYTE_W +: BYTE_W];
    assign grp_masked[g] = &lane_mask[g*BYTE_W +: BYTE_W];
  end

  assign hit = |lane_mis;
endmodule

// File: rtl/memtest_err_cnt.sv
module memtest_err_cnt
  import memtest_err_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LANES  = 72,
  parameter int GROUPS = 9,
  localparam int INC_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic              chunk_new,
  input  logic [1:0]        mode,
  input  logic [LANES-1:0]  lane_mis,
  input  logic [GROUPS-1:0] grp_mis,
  output logic [CNT_W-1:0]  cnt
);
  logic [INC_W-1:0] n_lane, n_grp, inc;
  logic [CNT_W:0]   sum;

  always_comb begin
    n_lane = '0;
    for (int i = 0; i < LANES; i++) n_lane = n_lane + INC_W'(lane_mis[i]);
    n_grp = '0;
    for (int i = 0; i < GROUPS; i++) n_grp = n_grp + INC_W'(grp_mis[i]);
    case (cnt_mode_e'(mode))
      CNT_CHAN:  inc = INC_W'(hit);
      CNT_LANE:  inc = n_lane;
      CNT_GRP:   inc = n_grp;
      default:   inc = INC_W'(chunk_new);
    endcase
    sum = {1'b0, cnt} + (CNT_W+1)'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (sum[CNT_W])   cnt <= '1;
    else                   cnt <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/memtest_stop_ctl.sv
module memtest_stop_ctl
  import memtest_err_pkg::*;
#(
  parameter int LANES  = 72,
  parameter int GROUPS = 9,
  parameter int NTH_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic [1:0]        mode,
  input  logic [NTH_W-1:0]  nth,
  input  logic [LANES-1:0]  lane_done,
  input  logic [GROUPS-1:0] grp_done,
  output logic              stop
);
  logic [NTH_W-1:0] evt, evt_nx;
  logic             fire;

  always_comb begin
    evt_nx = (hit && evt != '1) ? evt + 1'b1 : evt;
    case (stop_mode_e'(mode))
      STOP_NTH:      fire = hit && (evt_nx >= nth);
      STOP_ALL_GRP:  fire = hit && (&grp_done);
      STOP_ALL_LANE: fire = hit && (&lane_done);
      default:       fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      evt  <= '0;
      stop <= 1'b0;
    end else begin
      evt  <= evt_nx;
      stop <= stop | fire;
    end
  end
endmodule

// File: rtl/memtest_err_chk.sv
module memtest_err_chk
  import memtest_err_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ECC_W    = 8,
  parameter int CHUNKS   = 8,
  parameter int CL_EN_W  = 8,
  parameter int CL_IDX_W = 8,
  parameter int CNT_W    = 16,
  parameter int NTH_W    = 6,
  localparam int LANES   = DATA_W + ECC_W,
  localparam int GROUPS  = LANES / BYTE_W,
  localparam int CHK_W   = $clog2(CHUNKS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                cmp_vld_i,
  input  logic [DATA_W-1:0]   act_data_i,
  input  logic [DATA_W-1:0]   exp_data_i,
  input  logic [ECC_W-1:0]    act_ecc_i,
  input  logic [ECC_W-1:0]    exp_ecc_i,
  input  logic [CHK_W-1:0]    chunk_idx_i,
  input  logic [CL_IDX_W-1:0] cl_idx_i,
  input  logic [1:0]          stop_mode_i,
  input  logic [NTH_W-1:0]    nth_i,
  input  logic [CHUNKS-1:0]   chunk_en_i,
  input  logic [CL_EN_W-1:0]  cl_en_i,
  input  logic [DATA_W-1:0]   data_mask_i,
  input  logic [ECC_W-1:0]    ecc_mask_i,
  input  logic [1:0]          cnt_mode_i,
  output logic                stop_o,
  output logic [LANES-1:0]    lane_err_o,
  output logic [GROUPS-1:0]   grp_err_o,
  output logic [CNT_W-1:0]    err_cnt_o,
  output logic                chan_err_o
);
  logic [LANES-1:0]  lane_mask, lane_mis;
  logic [GROUPS-1:0] grp_mis, grp_masked;
  logic [CHUNKS-1:0] chunk_err;
  logic              hit, chunk_new;

  assign lane_mask = {ecc_mask_i, data_mask_i};

  memtest_lane_cmp #(
    .DATA_W(DATA_W), .ECC_W(ECC_W), .CHUNKS(CHUNKS),
    .CL_EN_W(CL_EN_W), .CL_IDX_W(CL_IDX_W)
  ) u_cmp (
    .vld(cmp_vld_i), .act_data(act_data_i), .exp_data(exp_data_i),
    .act_ecc(act_ecc_i), .exp_ecc(exp_ecc_i), .lane_mask(lane_mask),
    .chunk_en(chunk_en_i), .cl_en(cl_en_i), .chunk_idx(chunk_idx_i),
    .cl_idx(cl_idx_i), .lane_mis(lane_mis), .grp_mis(grp_mis),
    .grp_masked(grp_masked), .hit(hit)
  );

  assign chunk_new = hit && !chunk_err[chunk_idx_i];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      lane_err_o <= '0;
      grp_err_o  <= '0;
      chunk_err  <= '0;
      chan_err_o <= 1'b0;
    end else begin
      lane_err_o <= lane_err_o | lane_mis;
      grp_err_o  <= grp_err_o | grp_mis;
      if (hit) chunk_err[chunk_idx_i] <= 1'b1;
      chan_err_o <= chan_err_o | hit;
    end
  end

  memtest_err_cnt #(.CNT_W(CNT_W), .LANES(LANES), .GROUPS(GROUPS)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_i), .hit(hit), .chunk_new(chunk_new),
    .mode(cnt_mode_i), .lane_mis(lane_mis), .grp_mis(grp_mis), .cnt(err_cnt_o)
  );

  memtest_stop_ctl #(.LANES(LANES), .GROUPS(GROUPS), .NTH_W(NTH_W)) u_stop (
    .clk(clk), .rst(rst), .clr(clr_i), .hit(hit), .mode(stop_mode_i),
    .nth(nth_i),
    .lane_done(lane_err_o | lane_mis | lane_mask),
    .grp_done(grp_err_o | grp_mis | grp_masked),
    .stop(stop_o)
  );
endmodule

// File: rtl/memtest_err_sva.sv
module memtest_err_sva #(
  parameter int LANES  = 72,
  parameter int GROUPS = 9,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              cmp_vld_i,
  input logic [1:0]        stop_mode_i,
  input logic              stop_o,
  input logic [LANES-1:0]  lane_err_o,
  input logic [GROUPS-1:0] grp_err_o,
  input logic [CNT_W-1:0]  err_cnt_o,
  input logic              chan_err_o
);
  // R1: lane status only grows without a clear
  a_r1_lane_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((lane_err_o & $past(lane_err_o)) == $past(lane_err_o)));

  // R2: channel flag tracks the group vector
  a_r2_chan_flag: assert property (@(posedge clk) disable iff (rst)
    chan_err_o == (|grp_err_o));

  // R3: no strobe, no change
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!cmp_vld_i && !clr_i) |=> ($stable(lane_err_o) && $stable(err_cnt_o)));

  // R4: never-stop policy
  a_r4_never_stop: assert property (@(posedge clk) disable iff (rst)
    (!stop_o && stop_mode_i == 2'd0) |=> !stop_o);

  // R8: stop is sticky and follows a strobe
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    (stop_o && !clr_i) |=> stop_o);
  a_r8_stop_needs_cmp: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_o) |-> $past(cmp_vld_i));

  // R10: counter never wraps
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (err_cnt_o >= $past(err_cnt_o)));

  // R11: clear empties everything
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!stop_o && lane_err_o == '0 && grp_err_o == '0 &&
               err_cnt_o == '0 && !chan_err_o));
endmodule

bind memtest_err_chk memtest_err_sva #(
  .LANES(LANES), .GROUPS(GROUPS), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst(rst), .clr_i(clr_i), .cmp_vld_i(cmp_vld_i),
  .stop_mode_i(stop_mode_i), .stop_o(stop_o), .lane_err_o(lane_err_o),
  .grp_err_o(grp_err_o), .err_cnt_o(err_cnt_o), .chan_err_o(chan_err_o)
);

// File: tb/memtest_err_chk_tb.sv
module memtest_err_chk_tb_top;
  logic        clk = 1'b0, rst = 1'b1, clr = 1'b0, vld = 1'b0;
  logic [63:0] act_d, exp_d = 64'hA5C3_5A3C_0FF0_9669;
  logic [7:0]  act_e, exp_e = 8'h5A;
  logic [2:0]  chunk = '0;
  logic [7:0]  cl = '0;
  logic [1:0]  smode = 2'd0, cmode = 2'd0;
  logic [5:0]  nth = 6'd1;
  logic [7:0]  chunk_en = 8'hFF, cl_en = 8'hFF, emask = 8'h00;
  logic [63:0] dmask = '0;
  logic        stop, chan;
  logic [71:0] lane;
  logic [8:0]  grp;
  logic [15:0] cnt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign act_d = exp_d;
  assign act_e = exp_e;

  logic [71:0] xr = '0;
  memtest_err_chk dut_i (
    .clk(clk), .rst(rst), .clr_i(clr), .cmp_vld_i(vld),
    .act_data_i(act_d ^ xr[63:0]), .exp_data_i(exp_d),
    .act_ecc_i(act_e ^ xr[71:64]), .exp_ecc_i(exp_e),
    .chunk_idx_i(chunk), .cl_idx_i(cl), .stop_mode_i(smode), .nth_i(nth),
    .chunk_en_i(chunk_en), .cl_en_i(cl_en), .data_mask_i(dmask),
    .ecc_mask_i(emask), .cnt_mode_i(cmode), .stop_o(stop),
    .lane_err_o(lane), .grp_err_o(grp), .err_cnt_o(cnt), .chan_err_o(chan)
  );

  // {count code, mismatch lanes {ecc,data}, expected counter}
  localparam logic [81:0] VEC [8] = '{
    {2'd0, 72'h00_0000_0000_0000_0001, 8'd1},
    {2'd1, 72'h00_0000_0000_0000_00FF, 8'd8},
    {2'd1, 72'h04_8000_0000_0000_0201, 8'd4},
    {2'd2, 72'h04_8000_0000_0000_0201, 8'd4},
    {2'd2, 72'h00_0000_0000_0000_00FF, 8'd1},
    {2'd3, 72'h00_0000_0000_0000_0020, 8'd1},
    {2'd0, 72'h00_0000_0000_0000_0000, 8'd0},
    {2'd2, 72'hFF_FFFF_FFFF_FFFF_FFFF, 8'd9}
  };

  task automatic chk(input string req, input logic [71:0] got, input logic [71:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, want);
    end
  endtask

  task automatic cmp(input logic [71:0] x, input logic [2:0] ch, input logic [7:0] c);
    @(negedge clk);
    xr = x; chunk = ch; cl = c; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; xr = '0;
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 stop", 72'(stop), 72'd0);
    chk("R12 lanes", lane, 72'd0);
    chk("R12 cnt", 72'(cnt), 72'd0);
    chk("R12 chan", 72'(chan), 72'd0);

    // R9 / R2 table of count modes
    for (int i = 0; i < 8; i++) begin
      cmode = VEC[i][81:80];
      clear();
      cmp(VEC[i][79:8], 3'd0, 8'd0);
      chk($sformatf("R9 count entry %0d", i), 72'(cnt), 72'(VEC[i][7:0]));
      chk($sformatf("R1 lanes entry %0d", i), lane, VEC[i][79:8]);
      chk($sformatf("R2 chan entry %0d", i), 72'(chan), 72'(VEC[i][79:8] != 0));
    end
    chk("R2 groups all", 72'(grp), 72'h1FF);

    // R1 lane masking
    cmode = 2'd0; dmask = 64'h8; emask = 8'h01; clear();
    cmp({8'h03, 64'h18}, 3'd0, 8'd0);
    chk("R1 masked lanes", lane, {8'h02, 64'h10});
    dmask = '0; emask = '0;

    // R9 chunk mode: first error per chunk only
    cmode = 2'd3; clear();
    cmp(72'h1, 3'd2, 8'd0);
    cmp(72'h1, 3'd2, 8'd0);
    cmp(72'h1, 3'd4, 8'd0);
    chk("R9 chunk mode count", 72'(cnt), 72'd2);

    // R3 gating
    cmode = 2'd0; chunk_en = 8'hFE; clear();
    cmp(72'h1, 3'd0, 8'd0);
    chk("R3 chunk disabled", lane, 72'd0);
    chk("R3 chunk disabled cnt", 72'(cnt), 72'd0);
    cmp(72'h1, 3'd1, 8'd0);
    chk("R3 chunk enabled", lane, 72'd1);
    chunk_en = 8'hFF; cl_en = 8'hFB; clear();
    cmp(72'h2, 3'd0, 8'd10);
    chk("R3 cacheline 10 disabled", lane, 72'd0);
    cmp(72'h2, 3'd0, 8'd11);
    chk("R3 cacheline 11 enabled", lane, 72'd2);
    cl_en = 8'hFF;
    @(negedge clk); xr = 72'hF0;
    @(negedge clk); xr = '0;
    chk("R3 no strobe", lane, 72'd2);

    // R4 never stop
    smode = 2'd0; clear();
    for (int i = 0; i < 4; i++) cmp(72'hFF_FFFF_FFFF_FFFF_FFFF, 3'd0, 8'd0);
    chk("R4 no stop", 72'(stop), 72'd0);

    // R5 / R8 Nth error
    smode = 2'd1; nth = 6'd3; clear();
    cmp(72'h1, 3'd0, 8'd0);
    cmp(72'h0, 3'd0, 8'd0);
    cmp(72'h1, 3'd0, 8'd0);
    chk("R5 not yet at 2", 72'(stop), 72'd0);
    cmp(72'h1, 3'd0, 8'd0);
    chk("R5 stop at 3rd", 72'(stop), 72'd1);
    cmp(72'h0, 3'd0, 8'd0);
    chk("R8 stop sticky", 72'(stop), 72'd1);
    clear();
    chk("R11 stop cleared", 72'(stop), 72'd0);
    nth = 6'd0; clear();
    cmp(72'h1, 3'd0, 8'd0);
    chk("R5 N of zero", 72'(stop), 72'd1);

    // R6 all byte groups, group 3 fully masked
    smode = 2'd2; dmask = 64'h0000_0000_FF00_0000; clear();
    cmp({8'hFF, 64'hFFFF_00FF_FFFF_FFFF}, 3'd0, 8'd0);
    chk("R6 groups so far", 72'(grp), 72'h1D7);
    chk("R6 not all groups", 72'(stop), 72'd0);
    cmp(72'h100_0000_0000, 3'd0, 8'd0);
    chk("R6 all groups stop", 72'(stop), 72'd1);

    // R7 all lanes, only lanes 0..3 unmasked
    smode = 2'd3; dmask = ~64'hF; emask = 8'hFF; clear();
    cmp(72'h7, 3'd0, 8'd0);
    chk("R7 not all lanes", 72'(stop), 72'd0);
    cmp(72'h8, 3'd0, 8'd0);
    chk("R7 all lanes stop", 72'(stop), 72'd1);
    dmask = '0; emask = '0; smode = 2'd0;

    // R10 saturation
    cmode = 2'd1; clear();
    for (int i = 0; i < 912; i++) cmp(72'hFF_FFFF_FFFF_FFFF_FFFF, 3'd0, 8'd0);
    chk("R10 saturated", 72'(cnt), 72'hFFFF);

    // R11 clear wins over same-cycle compare
    @(negedge clk); clr = 1'b1; vld = 1'b1; xr = 72'h5;
    @(negedge clk); clr = 1'b0; vld = 1'b0; xr = '0;
    chk("R11 lanes cleared", lane, 72'd0);
    chk("R11 cnt cleared", 72'(cnt), 72'd0);
    chk("R11 chan cleared", 72'(chan), 72'd0);

    done();
  end
endmodule